// File: doc/BRIEF.md
# Quadratic Polynomial Unit with Overflow

This block evaluates the polynomial Z = X·X + 2·X + 3 for an unsigned operand X. X is N bits wide, with a default of N = 5. The result is returned in 2N bits. A separate flag is raised whenever the exact value does not fit in that width. The block has no clock and no state: both outputs follow the operand through pure combinational logic.

Internally the exact sum is built in 2N+1 bits. The low 2N bits drive Z, and any set bit above them drives the overflow flag. With N = 5 the largest exact value is 31·31 + 62 + 3 = 1026. Only the all-ones operand exceeds the 10-bit range. In that case Z wraps to 2 and the flag is set.

Top module: `quad_poly_unit`

## Requirements
- R1: `z_out` equals the low 2N bits of X·X + 2·X + 3, computed exactly, for every value of `x_in`.
- R2: `ovf_out` is 1 exactly when the exact value of X·X + 2·X + 3 is 2^(2N) or more, and 0 otherwise.
- R3: With N = 5, only X = 31 (all ones) overflows. For that operand `z_out` reads 2 and `ovf_out` reads 1.
- R4: With N = 5, X = 30 gives `z_out` = 963 and `ovf_out` = 0. This is the largest operand that does not overflow.
- R5: X = 0 gives `z_out` = 3 and `ovf_out` = 0.
- R6: The block holds no state. A change on `x_in` reaches both outputs without any clock edge, and the same operand always gives the same outputs, whatever came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | N | Unsigned operand X |
| z_out | output | 2N | Low 2N bits of X·X + 2·X + 3 |
| ovf_out | output | 1 | Set when the exact value does not fit in 2N bits |

## Verification
Both results are due in the same time step as the operand, with zero clock cycles of latency.

The bench drives `x_in` on the falling edge of its pacing clock. It samples one time unit later, long before the next rising edge, so no register could be the cause of a correct answer.

For R6, the bench changes the operand and samples with no clock edge in between. It also revisits operands after different predecessors and checks that the outputs are identical.

// File: rtl/quad_poly_pkg.sv
package quad_poly_pkg;

  // Width of the truncated result for an n-bit operand.
  function automatic int res_width(input int n);
    return 2 * n;
  endfunction

  // Width that holds the exact value: max is 2^(2n) + 2.
  function automatic int exact_width(input int n);
    return 2 * n + 1;
  endfunction

  // Width of the linear term 2X + 3.
  function automatic int lin_width(input int n);
    return n + 2;
  endfunction

endpackage

// File: rtl/qp_square.sv
module qp_square #(
  parameter int N = 5,
  localparam int W = quad_poly_pkg::res_width(N)
) (
  input  logic [N-1:0] x_in,
  output logic [W-1:0] sq_out
);

  logic [W-1:0] x_ext;
  logic [W-1:0] acc [N+1];

  assign x_ext  = W'(x_in);
  assign acc[0] = '0;

  // Shift-and-add array: row i adds X << i when bit i of X is set.
  for (genvar i = 0; i < N; i++) begin : g_row
    logic [W-1:0] pp;
    assign pp       = x_in[i] ? (x_ext << i) : '0;
    assign acc[i+1] = acc[i] + pp;
  end

  assign sq_out = acc[N];

endmodule

// File: rtl/qp_linear.sv
module qp_linear #(
  parameter int N = 5,
  localparam int LW = quad_poly_pkg::lin_width(N)
) (
  input  logic [N-1:0]  x_in,
  output logic [LW-1:0] lin_out
);

  // 2X + 3: shift left by one, then add the constant.
  assign lin_out = {1'b0, x_in, 1'b0} + LW'(3);

endmodule

// File: rtl/qp_split.sv
module qp_split #(
  parameter int N = 5,
  localparam int W  = quad_poly_pkg::res_width(N),
  localparam int EW = quad_poly_pkg::exact_width(N),
  localparam int HW = EW - W
) (
  input  logic [EW-1:0] exact_in,
  output logic [W-1:0]  z_out,
  output logic          ovf_out
);

  assign z_out = exact_in[W-1:0];

  // Any bit above the result width means the value did not fit.
  logic [HW-1:0] hi;
  assign hi      = exact_in[EW-1:W];
  assign ovf_out = |hi;

endmodule

// File: rtl/quad_poly_unit.sv
module quad_poly_unit #(
  parameter int N = 5,
  localparam int W  = quad_poly_pkg::res_width(N),
  localparam int EW = quad_poly_pkg::exact_width(N),
  localparam int LW = quad_poly_pkg::lin_width(N)
) (
  input  logic [N-1:0] x_in,
  output logic [W-1:0] z_out,
  output logic         ovf_out
);

  logic [W-1:0]  sq;
  logic [LW-1:0] lin;
  logic [EW-1:0] exact;

  qp_square #(.N(N)) u_square (
    .x_in   (x_in),
    .sq_out (sq)
  );

  qp_linear #(.N(N)) u_linear (
    .x_in    (x_in),
    .lin_out (lin)
  );

  assign exact = EW'(sq) + EW'(lin);

  qp_split #(.N(N)) u_split (
    .exact_in (exact),
    .z_out    (z_out),
    .ovf_out  (ovf_out)
  );

endmodule

// File: rtl/qp_checker.sv
module qp_checker #(
  parameter int N = 5,
  localparam int W = 2 * N
) (
  input logic [N-1:0] x_in,
  input logic [W-1:0] z_out,
  input logic         ovf_out
);

  // Independent form: (X + 1)^2 + 2, in wide integer arithmetic.
  longint unsigned ref_val;
  always_comb ref_val = (longint'(x_in) + 1) * (longint'(x_in) + 1) + 2;

  always_comb begin
    // R1: low bits match the exact polynomial.
    p_low_bits_r1: assert (longint'(z_out) == (ref_val % (64'd1 << W)));
    // R2: flag tracks whether the exact value exceeds the range.
    p_flag_range_r2: assert (ovf_out == (ref_val >= (64'd1 << W)));
    // R3: an overflow can only come from the all-ones operand, wrapping to 2.
    if (ovf_out) begin
      p_ovf_allones_r3: assert (&x_in);
      p_ovf_wrap_r3: assert (z_out == W'(2));
    end
    // R4: all-ones minus one never overflows.
    if (x_in == {{(N-1){1'b1}}, 1'b0}) begin
      p_no_overflow_r4: assert (!ovf_out);
    end
    // R5: zero operand gives the constant term.
    if (x_in == '0) begin
      p_zero_const_r5: assert (z_out == W'(3) && !ovf_out);
    end
  end

endmodule

bind quad_poly_unit qp_checker #(.N(N)) u_chk (
  .x_in    (x_in),
  .z_out   (z_out),
  .ovf_out (ovf_out)
);

// File: tb/quad_poly_unit_tb.sv
module quad_poly_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int W = 2 * N;
  localparam int NV = 10;

  // Packed vector: {x[4:0], z[9:0], ovf}
  localparam logic [15:0] VEC [NV] = '{
    {5'd0,  10'd3,   1'b0},
    {5'd1,  10'd6,   1'b0},
    {5'd2,  10'd11,  1'b0},
    {5'd3,  10'd18,  1'b0},
    {5'd7,  10'd66,  1'b0},
    {5'd15, 10'd258, 1'b0},
    {5'd16, 10'd291, 1'b0},
    {5'd20, 10'd443, 1'b0},
    {5'd30, 10'd963, 1'b0},
    {5'd31, 10'd2,   1'b1}
  };

  logic         clk = 1'b0;
  logic [N-1:0] x_in = '0;
  logic [W-1:0] z_out;
  logic         ovf_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_poly_unit #(.N(N)) u_dut (
    .x_in    (x_in),
    .z_out   (z_out),
    .ovf_out (ovf_out)
  );

  task automatic check(input string req, input logic [W-1:0] ez, input logic eo);
    n_checks++;
    if (z_out !== ez || ovf_out !== eo) begin
      n_fail++;
      $display("FAIL %s x=%0d: z=%0d ovf=%0b expected z=%0d ovf=%0b",
               req, x_in, z_out, ovf_out, ez, eo);
    end
  endtask

  task automatic apply(input logic [N-1:0] v);
    @(negedge clk);
    x_in = v;
    #1;
  endtask

  initial begin
    // Initial state: operand 0 before any clock edge (R5)
    #1;
    check("R5", 10'd3, 1'b0);

    // Table walk (R1, R2, R3, R4, R5)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15:11]);
      check(VEC[i][15:11] == 5'd31 ? "R3" :
            VEC[i][15:11] == 5'd30 ? "R4" : "R1", VEC[i][10:1], VEC[i][0]);
    end

    // Exhaustive sweep against (X+1)^2 + 2 (R1, R2)
    for (int x = 0; x < (1 << N); x++) begin
      int e;
      apply(N'(x));
      e = (x + 1) * (x + 1) + 2;
      check(e >= (1 << W) ? "R2" : "R1", W'(e), e >= (1 << W));
    end

    // R6: changes with no clock edge in between
    @(posedge clk);
    #1;
    x_in = 5'd31;
    #1;
    check("R6", 10'd2, 1'b1);
    x_in = 5'd30;
    #1;
    check("R6", 10'd963, 1'b0);
    x_in = 5'd0;
    #1;
    check("R6", 10'd3, 1'b0);

    // R6: same operand after different predecessors
    apply(5'd31);
    apply(5'd16);
    check("R6", 10'd291, 1'b0);
    apply(5'd0);
    apply(5'd16);
    check("R6", 10'd291, 1'b0);

    // Corner: overflow operand back to zero (R3, R5)
    apply(5'd31);
    check("R3", 10'd2, 1'b1);
    apply(5'd0);
    check("R5", 10'd3, 1'b0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule